// File: doc/BRIEF.md
# Vectored Interrupt Mask Controller

This block sits next to a small 8-bit processor core and arbitrates its interrupt requests. Eight request lines feed a sticky pending register. An 8-bit enable mask filters the pending bits. A fixed-priority encoder then picks one source, where the lowest index wins. The block gives the core a request level, the winning source number and the 16-bit address of that source's vector entry. Each entry is two bytes wide, so source n sits at base + 2·n. The core acknowledges the request it takes, and the acknowledge clears the pending bit of the winning source.

The block holds the mask register, which the core's set-mask instruction writes. It also keeps the core's interrupt-disable bit (the I-bit), which the core updates through a write port. Build options decide four things:
- whether source 0 can be masked at all;
- whether service entry is blocked while the I-bit is set;
- whether mask writes need the I-bit (supervisor mode), which also brings the I-bit up set out of reset;
- which status flag bits come back from the saved copy on return from interrupt.

The flag merge is combinational. The core gives it the saved and current flag bytes and takes the merged byte back.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset there is no pending request and `irq_req` is 0. `mask_out` equals the reset mask value, with bit 0 forced to 1 when the non-maskable option is on. `ibit_out` is 1 in supervisor mode and 0 otherwise.
- R2: A request line that is high in a cycle sets its pending bit at that clock edge. The bit stays set until it is acknowledged.
- R3: `irq_req` is 1 when any pending bit has its mask bit at 1 and service is not gated. `irq_id` is then the lowest such index, because index 0 has the highest priority.
- R4: While `irq_req` is 1, `vec_addr` equals the vector base plus 2 × `irq_id`, computed modulo 2^16.
- R5: `irq_ack` while `irq_req` is 1 clears the pending bit of the source shown in `irq_id`. The exception is when that source's line is high in the same cycle, in which case the bit stays set. `irq_ack` while `irq_req` is 0 changes nothing.
- R6: A permitted `mask_wr_en` loads `mask_wr_data` into the mask at the clock edge. A mask bit of 1 enables its source. A masked pending bit is kept and is served once it is unmasked.
- R7: With the non-maskable option on, bit 0 of `mask_out` is always 1, whatever value is written.
- R8: With the sequential option on, `irq_req` stays 0 while `ibit_out` is 1. This holds even for source 0.
- R9: `rti_flags[3:0]` always equals `rti_saved_flags[3:0]`. `rti_flags[7:4]` comes from `rti_saved_flags` by default, and from `rti_cur_flags` when the keep-upper-flags option is on.
- R10: In supervisor mode, a mask write takes effect only while `ibit_out` is 1. At other times it leaves the mask unchanged.
- R11: `ibit_wr_en` loads `ibit_wr_val` into the I-bit at the clock edge, and the new value shows on `ibit_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Request lines, one per source |
| irq_ack | input | 1 | Core takes the presented interrupt |
| mask_wr_en | input | 1 | Set-mask write strobe |
| mask_wr_data | input | 8 | New mask value |
| ibit_wr_en | input | 1 | I-bit update strobe |
| ibit_wr_val | input | 1 | New I-bit value |
| rti_saved_flags | input | 8 | Flag byte saved at service entry |
| rti_cur_flags | input | 8 | Flag byte at the time of return |
| irq_req | output | 1 | An enabled request is waiting for service |
| irq_id | output | 3 | Winning source number |
| vec_addr | output | 16 | Address of the winner's vector entry |
| mask_out | output | 8 | Effective mask |
| ibit_out | output | 1 | Current I-bit |
| rti_flags | output | 8 | Merged flag byte for the return |

## Verification
Two instances run side by side on the same inputs. One uses the defaults: source 0 non-maskable, with no gating and no supervisor rule. The other turns on sequential gating, supervisor mode and keep-upper-flags, with a different base and reset mask. Directed steps cover three groups of cases:
- single and multiple pending sources, to separate correct priority from wrong priority;
- an acknowledge with and without a request, and an acknowledge that collides with a new edge on the same line, to separate a correct clear from a lost or stale request;
- mask writes with the I-bit both set and clear, to separate supervisor and non-maskable handling from a plain register.

Sparse random request bursts, mixed with random acknowledges, mask writes and I-bit writes, then check that pending state, gating and vector arithmetic stay consistent over long interleavings.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;
   localparam int VEC_W = 16;

   function automatic logic [VEC_W-1:0] vec_entry(input logic [VEC_W-1:0] base,
                                                  input logic [VEC_W-1:0] idx,
                                                  input int shift);
      return base + (idx << shift);
   endfunction
endpackage

// File: rtl/irqv_pending.sv
`timescale 1ns/1ps
module irqv_pending #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= (pend_o & ~clr_i) | set_i;
   end

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R2
endmodule

// File: rtl/irqv_mask.sv
`timescale 1ns/1ps
module irqv_mask #(
   parameter int               NUM_SRC    = 8,
   parameter logic [NUM_SRC-1:0] MASK_INIT = '1,
   parameter bit               NMI_EN     = 1'b1,
   parameter bit               SUPERVISOR = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [NUM_SRC-1:0] wr_data,
   input  logic               ibit,
   output logic [NUM_SRC-1:0] mask_o
);
   logic               wr_ok;
   logic [NUM_SRC-1:0] mask_q;

   generate
      if (SUPERVISOR) begin : g_sup
         assign wr_ok = wr_en & ibit;
      end else begin : g_free
         assign wr_ok = wr_en;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q <= MASK_INIT;
      else if (wr_ok) mask_q <= wr_data;
   end

   generate
      if (NMI_EN) begin : g_nmi
         assign mask_o = {mask_q[NUM_SRC-1:1], 1'b1};
      end else begin : g_plain
         assign mask_o = mask_q;
      end
   endgenerate

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> (mask_o[NUM_SRC-1:1] == $past(wr_data[NUM_SRC-1:1]))); // R6

   generate
      if (SUPERVISOR) begin : g_sup_chk
         AST_SUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !ibit) |=> $stable(mask_o)); // R10
      end
   endgenerate
endmodule

// File: rtl/irqv_prio.sv
`timescale 1ns/1ps
module irqv_prio #(
   parameter int NUM_SRC = 8,
   parameter int IDW     = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] cand_i,
   output logic               any_o,
   output logic [IDW-1:0]     id_o,
   output logic [NUM_SRC-1:0] onehot_o
);
   always_comb begin
      id_o     = '0;
      onehot_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (cand_i[i]) begin
            id_o        = IDW'(i);
            onehot_o    = '0;
            onehot_o[i] = 1'b1;
         end
      end
      any_o = |cand_i;
   end
endmodule

// File: rtl/irqv_flag_merge.sv
`timescale 1ns/1ps
module irqv_flag_merge #(
   parameter int FLAG_W   = 8,
   parameter int FLAG_LOW = 4,
   parameter bit KEEP_GP  = 1'b0
) (
   input  logic [FLAG_W-1:0] saved_i,
   input  logic [FLAG_W-1:0] cur_i,
   output logic [FLAG_W-1:0] flags_o
);
   generate
      if (KEEP_GP) begin : g_keep
         assign flags_o = {cur_i[FLAG_W-1:FLAG_LOW], saved_i[FLAG_LOW-1:0]};
      end else begin : g_all
         assign flags_o = saved_i;
      end
   endgenerate
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl #(
   parameter int                 NUM_SRC     = 8,
   parameter logic [15:0]        VEC_BASE    = 16'hFFF0,
   parameter int                 ENTRY_SHIFT = 1,
   parameter logic [NUM_SRC-1:0] MASK_INIT   = '1,
   parameter bit                 NMI_EN      = 1'b1,
   parameter bit                 SEQ_EN      = 1'b0,
   parameter bit                 KEEP_GP     = 1'b0,
   parameter bit                 SUPERVISOR  = 1'b0,
   parameter int                 FLAG_W      = 8,
   parameter int                 FLAG_LOW    = 4,
   localparam int                IDW         = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               irq_ack,
   input  logic               mask_wr_en,
   input  logic [NUM_SRC-1:0] mask_wr_data,
   input  logic               ibit_wr_en,
   input  logic               ibit_wr_val,
   input  logic [FLAG_W-1:0]  rti_saved_flags,
   input  logic [FLAG_W-1:0]  rti_cur_flags,
   output logic               irq_req,
   output logic [IDW-1:0]     irq_id,
   output logic [15:0]        vec_addr,
   output logic [NUM_SRC-1:0] mask_out,
   output logic               ibit_out,
   output logic [FLAG_W-1:0]  rti_flags
);
   import irqv_pkg::*;

   generate
      if (NUM_SRC < 2 || NUM_SRC > 16) begin : g_bad_src
         $error("irq_vector_ctrl: NUM_SRC must be within 2..16");
      end
      if (FLAG_LOW < 1 || FLAG_LOW >= FLAG_W) begin : g_bad_flag
         $error("irq_vector_ctrl: FLAG_LOW must lie inside the flag byte");
      end
      if (ENTRY_SHIFT < 0 || ENTRY_SHIFT > 4) begin : g_bad_shift
         $error("irq_vector_ctrl: ENTRY_SHIFT out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] clr_sel;
   logic [NUM_SRC-1:0] cand;
   logic [NUM_SRC-1:0] sel_onehot;
   logic               any_cand;
   logic               gate_open;
   logic               ibit_q;

   // I-bit register, reset state picked by supervisor option
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ibit_q <= SUPERVISOR;
      else if (ibit_wr_en) ibit_q <= ibit_wr_val;
   end
   assign ibit_out = ibit_q;

   generate
      if (SEQ_EN) begin : g_seq
         assign gate_open = ~ibit_q;
      end else begin : g_nest
         assign gate_open = 1'b1;
      end
   endgenerate

   irqv_mask #(
      .NUM_SRC    (NUM_SRC),
      .MASK_INIT  (MASK_INIT),
      .NMI_EN     (NMI_EN),
      .SUPERVISOR (SUPERVISOR)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mask_wr_en),
      .wr_data (mask_wr_data),
      .ibit    (ibit_q),
      .mask_o  (mask_out)
   );

   assign clr_sel = (irq_ack && irq_req) ? sel_onehot : '0;

   irqv_pending #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (irq_in),
      .clr_i  (clr_sel),
      .pend_o (pend_q)
   );

   assign cand = pend_q & mask_out & {NUM_SRC{gate_open}};

   irqv_prio #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_prio (
      .cand_i   (cand),
      .any_o    (any_cand),
      .id_o     (irq_id),
      .onehot_o (sel_onehot)
   );

   assign irq_req  = any_cand;
   assign vec_addr = vec_entry(VEC_BASE, 16'(irq_id), ENTRY_SHIFT);

   irqv_flag_merge #(
      .FLAG_W   (FLAG_W),
      .FLAG_LOW (FLAG_LOW),
      .KEEP_GP  (KEEP_GP)
   ) u_flags (
      .saved_i (rti_saved_flags),
      .cur_i   (rti_cur_flags),
      .flags_o (rti_flags)
   );

   AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend_q[irq_id] && mask_out[irq_id])); // R3
   AST_NO_HIGHER_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((pend_q & mask_out & ((NUM_SRC'(1) << irq_id) - NUM_SRC'(1))) == '0)); // R3
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req && !irq_in[irq_id]) |=> !pend_q[$past(irq_id)]); // R5
   AST_IBIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ibit_wr_en |=> (ibit_out == $past(ibit_wr_val))); // R11

   generate
      if (SEQ_EN) begin : g_seq_chk
         AST_SEQ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            ibit_out |-> !irq_req); // R8
      end
      if (NMI_EN) begin : g_nmi_chk
         AST_NMI_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
            mask_wr_en |=> mask_out[0]); // R7
      end
   endgenerate
endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [7:0] irq_in = '0;
   logic       irq_ack = 1'b0;
   logic       mask_wr_en = 1'b0;
   logic [7:0] mask_wr_data = '0;
   logic       ibit_wr_en = 1'b0;
   logic       ibit_wr_val = 1'b0;
   logic [7:0] sflags = '0;
   logic [7:0] cflags = '0;

   logic [1:0]  o_req;
   logic [2:0]  o_id   [2];
   logic [15:0] o_vec  [2];
   logic [7:0]  o_mask [2];
   logic [1:0]  o_ib;
   logic [7:0]  o_fl   [2];

   // configuration table of both instances
   localparam logic [15:0] C_BASE [2] = '{16'hFFF0, 16'h2000};
   localparam logic [7:0]  C_INIT [2] = '{8'hFF, 8'h5A};
   localparam bit          C_NMI  [2] = '{1'b1, 1'b0};
   localparam bit          C_SEQ  [2] = '{1'b0, 1'b1};
   localparam bit          C_KEEP [2] = '{1'b0, 1'b1};
   localparam bit          C_SUP  [2] = '{1'b0, 1'b1};

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_ack(irq_ack),
      .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
      .ibit_wr_en(ibit_wr_en), .ibit_wr_val(ibit_wr_val),
      .rti_saved_flags(sflags), .rti_cur_flags(cflags),
      .irq_req(o_req[0]), .irq_id(o_id[0]), .vec_addr(o_vec[0]),
      .mask_out(o_mask[0]), .ibit_out(o_ib[0]), .rti_flags(o_fl[0]));

   irq_vector_ctrl #(
      .VEC_BASE(16'h2000), .MASK_INIT(8'h5A), .NMI_EN(1'b0), .SEQ_EN(1'b1),
      .KEEP_GP(1'b1), .SUPERVISOR(1'b1)
   ) i_irq_vector_ctrl_alt (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_ack(irq_ack),
      .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
      .ibit_wr_en(ibit_wr_en), .ibit_wr_val(ibit_wr_val),
      .rti_saved_flags(sflags), .rti_cur_flags(cflags),
      .irq_req(o_req[1]), .irq_id(o_id[1]), .vec_addr(o_vec[1]),
      .mask_out(o_mask[1]), .ibit_out(o_ib[1]), .rti_flags(o_fl[1]));

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [7:0] m_pend [2];
   logic [7:0] m_mask [2];
   bit         m_ib   [2];

   function automatic bit exp_req(int c);
      return !(C_SEQ[c] && m_ib[c]) && ((m_pend[c] & m_mask[c]) != 8'h00);
   endfunction

   function automatic logic [2:0] exp_id(int c);
      logic [7:0] v = m_pend[c] & m_mask[c];
      for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
      return 3'd0;
   endfunction

   function automatic logic [7:0] exp_flags(int c, logic [7:0] s, logic [7:0] k);
      return C_KEEP[c] ? {k[7:4], s[3:0]} : s;
   endfunction

   task automatic chk(string tag, int c, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s inst%0d %s: actual %h expected %h", tag, c, what, act, exp);
      end
   endtask

   task automatic compare_state(string tag);
      for (int c = 0; c < 2; c++) begin
         chk(tag, c, "irq_req", 32'(o_req[c]), 32'(exp_req(c)));
         if (exp_req(c)) begin
            chk(tag, c, "irq_id", 32'(o_id[c]), 32'(exp_id(c)));
            chk(tag, c, "vec_addr", 32'(o_vec[c]),
                32'(16'(C_BASE[c] + 16'({exp_id(c), 1'b0}))));
         end
         chk(tag, c, "mask_out", 32'(o_mask[c]), 32'(m_mask[c]));
         chk(tag, c, "ibit_out", 32'(o_ib[c]), 32'(m_ib[c]));
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_pend[c] = 8'h00;
         m_mask[c] = C_INIT[c] | (C_NMI[c] ? 8'h01 : 8'h00);
         m_ib[c]   = C_SUP[c];
      end
   endtask

   task automatic step(string tag, logic [7:0] irq, bit ack, bit mwe, logic [7:0] mwd,
                       bit iwe, bit iwv, logic [7:0] sf, logic [7:0] cf);
      irq_in = irq; irq_ack = ack; mask_wr_en = mwe; mask_wr_data = mwd;
      ibit_wr_en = iwe; ibit_wr_val = iwv; sflags = sf; cflags = cf;
      #1;
      for (int c = 0; c < 2; c++)
         chk("R9 flag merge", c, "rti_flags", 32'(o_fl[c]), 32'(exp_flags(c, sf, cf)));
      for (int c = 0; c < 2; c++) begin
         if (ack && exp_req(c)) m_pend[c] = m_pend[c] & ~(8'h01 << exp_id(c));
         m_pend[c] = m_pend[c] | irq;
         if (mwe && (!C_SUP[c] || m_ib[c]))
            m_mask[c] = mwd | (C_NMI[c] ? 8'h01 : 8'h00);
         if (iwe) m_ib[c] = iwv;
      end
      @(posedge clk);
      @(negedge clk);
      irq_in = '0; irq_ack = 1'b0; mask_wr_en = 1'b0; ibit_wr_en = 1'b0;
      compare_state(tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      model_reset();
      repeat (3) @(negedge clk);
      compare_state("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      compare_state("R1 after release");

      // directed corner cases
      step("R2 R3 R4 R8 two sources", 8'h28, 0, 0, 8'h00, 0, 0, 8'hA5, 8'h3C);
      step("R5 ack clears winner",    8'h00, 1, 0, 8'h00, 0, 0, 8'h5A, 8'hC3);
      step("R11 clear ibit",          8'h00, 0, 0, 8'h00, 1, 0, 8'hFF, 8'h00);
      step("R7 R10 write zero mask",  8'h00, 0, 1, 8'h00, 0, 0, 8'h00, 8'hFF);
      step("R6 unmask held source",   8'h00, 0, 1, 8'h20, 0, 0, 8'h0F, 8'hF0);
      step("R11 set ibit",            8'h00, 0, 0, 8'h00, 1, 1, 8'h12, 8'h34);
      step("R10 write under ibit",    8'h00, 0, 1, 8'h01, 0, 0, 8'h00, 8'h00);
      step("R8 source 0 blocked",     8'h01, 0, 0, 8'h00, 0, 0, 8'h00, 8'h00);
      step("R5 ack collides new req", 8'h01, 1, 0, 8'h00, 0, 0, 8'h00, 8'h00);
      step("R5 ack source 0",         8'h00, 1, 0, 8'h00, 0, 0, 8'h00, 8'h00);
      step("R5 ack with no request",  8'h00, 1, 0, 8'h00, 1, 0, 8'h00, 8'h00);
      step("R3 R4 all lines",         8'hFF, 0, 1, 8'hFE, 0, 0, 8'h99, 8'h66);
      step("R4 highest index",        8'h00, 0, 1, 8'h80, 0, 0, 8'h00, 8'h00);

      // constrained random traffic
      for (int k = 0; k < 600; k++) begin
         logic [7:0] r_irq;
         r_irq = ($urandom % 4 == 0) ? (8'($urandom) & 8'($urandom)) : 8'h00;
         step("R2 R3 R4 R5 R6 random", r_irq, ($urandom % 3) == 0,
              ($urandom % 8) == 0, 8'($urandom),
              ($urandom % 6) == 0, 1'($urandom),
              8'($urandom), 8'($urandom));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule